// File: doc/BRIEF.md
# Four-phase instruction cycle sequencer

This block turns an oscillator clock into a repeating instruction cycle of four equal phases, in the order decode, read, process and write. It runs the fetch and execute halves of a small accumulator core as a two-stage overlap. While one instruction moves through the four phases of a cycle, the next one is captured from program memory. The instruction-cycle enable therefore runs at one quarter of the oscillator rate. The peripheral enable is asserted on every oscillator clock.

Each phase has its own job. The decode phase latches the opcode of the executing instruction. The read phase latches its immediate operand. The process phase computes the result. The write phase commits the result to the accumulator and hands the next instruction over. A taken branch is seen only at the close of the write phase. It reloads the program counter, and the instruction already fetched is replaced by a no-operation, so the cycle after the branch runs as a bubble.

Top module: `qcyc_sequencer`

## Requirements
- R1: `phase_oh` has exactly one bit set in every oscillator cycle. The bits mean: bit 0 decode, bit 1 read, bit 2 process, bit 3 write. Its value during reset is 4'b0001.
- R2: The phases advance by one bit per oscillator clock, in the order bit 0, bit 1, bit 2, bit 3, and then back to bit 0.
- R3: `cyc_en` is high only during the write phase. It is therefore high for one clock out of every four.
- R4: `periph_en` is low during reset. From the first clock edge after reset it is high on every oscillator cycle.
- R5: Reset clears the program counter and the accumulator to 0 and loads a NOP as the executing instruction. As a result, the first instruction cycle produces no write strobe.
- R6: The instruction word has an opcode in bits [7:6] and a zero-extended immediate in bits [5:0]. The opcodes are: 00 NOP; 01 ADD (acc += imm); 10 LOAD (acc = imm); 11 SUB (acc -= imm). The arithmetic is modulo 256.
- R7: The accumulator changes only at the clock edge that ends a write phase. `wr_stb` is high during the write phase exactly when the executing instruction is not a NOP. While it is high, `wr_data` equals the value the accumulator takes at that edge.
- R8: The instruction read from `imem_addr` during cycle N executes in cycle N+1. Without a branch, `imem_addr` increases by 1 (wrapping modulo 64) at the end of each cycle and holds steady within a cycle.
- R9: When `branch_taken` is high at the edge that ends a write phase, the program counter loads `branch_target`. The instruction fetched in that cycle is replaced by a NOP, so the next cycle performs no write.
- R10: When `branch_taken` is high at any edge other than the end of a write phase, it has no effect on the program counter or on execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| branch_taken | input | 1 | Branch request, acted on at the end of the write phase |
| branch_target | input | 6 | Program counter value to load on a branch |
| imem_data | input | 8 | Instruction word at `imem_addr` |
| imem_addr | output | 6 | Program counter, used as the fetch address |
| phase_oh | output | 4 | One-hot phase strobes: decode, read, process, write |
| cyc_en | output | 1 | Instruction-cycle enable, high during the write phase |
| periph_en | output | 1 | Peripheral enable, high on every clock after reset |
| wr_stb | output | 1 | Result write strobe |
| wr_data | output | 8 | Result being written |
| acc | output | 8 | Accumulator |

## Verification
The hardest case to reach is a branch request that lands on the wrong phase. The pulse must be high across decode and read edges but low at the write-phase edge, and the bench must then show that neither the fetch address nor the pre-fetched instruction changed. The bench reaches this by tracking the phase from `phase_oh`. It drives `branch_taken` at chosen falling edges inside a cycle and compares the address and the accumulator against its own pipeline model for the following cycles. The real squash is placed across a program-counter wrap, so that the bubble and the wrap from address 63 to 0 occur in consecutive cycles.

// File: rtl/qcyc_pkg.sv
`timescale 1ns/1ps
package qcyc_pkg;
    localparam int PHASES = 4;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_ADD  = 2'b01,
        OP_LOAD = 2'b10,
        OP_SUB  = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_READ    = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;
endpackage

// File: rtl/qcyc_phase_gen.sv
`timescale 1ns/1ps
module qcyc_phase_gen
    import qcyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output phase_e            phase,
    output logic [PHASES-1:0] phase_oh,
    output logic              cyc_last,
    output logic              periph_en
);
    localparam int PHW = $clog2(PHASES);

    typedef struct packed {
        logic [PHW-1:0] cnt;
        logic           pen;
    } pg_state_t;

    pg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == PHW'(PHASES - 1))
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + PHW'(1);
        s_d.pen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    genvar g;
    generate
        for (g = 0; g < PHASES; g++) begin : g_strobe
            assign phase_oh[g] = (s_q.cnt == PHW'(g));
        end
    endgenerate

    assign phase     = phase_e'(s_q.cnt);
    assign cyc_last  = phase_oh[PHASES-1];
    assign periph_en = s_q.pen;

    // R2: the last phase is always followed by the first
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[PHASES-1] |=> phase_oh[0]);
    // R2: the first phase is always followed by the second
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |=> phase_oh[1]);
endmodule

// File: rtl/qcyc_fetch.sv
`timescale 1ns/1ps
module qcyc_fetch #(
    parameter int IW  = 8,
    parameter int PCW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_fetch,
    input  logic           advance,
    input  logic           branch_taken,
    input  logic [PCW-1:0] branch_target,
    input  logic [IW-1:0]  imem_data,
    output logic [PCW-1:0] pc,
    output logic [IW-1:0]  fetched
);
    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [IW-1:0]  fetch;
    } fetch_state_t;

    fetch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_fetch)
            s_d.fetch = imem_data;
        if (advance) begin
            if (branch_taken)
                s_d.pc = branch_target;
            else
                s_d.pc = s_q.pc + PCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign pc      = s_q.pc;
    assign fetched = s_q.fetch;

    // R8: the program counter is steady inside an instruction cycle
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pc));
    // R8: without a branch, the program counter steps by one at the cycle end
    assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !branch_taken) |=> (pc == $past(pc) + PCW'(1)));
    // R9: a branch at the cycle end loads the target
    assert_branch_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && branch_taken) |=> (pc == $past(branch_target)));
endmodule

// File: rtl/qcyc_exec.sv
`timescale 1ns/1ps
module qcyc_exec
    import qcyc_pkg::*;
#(
    parameter int IW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic          squash,
    input  logic [IW-1:0] fetched,
    output logic [DW-1:0] acc,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);
    localparam int OPW = IW - 2;

    typedef struct packed {
        logic [IW-1:0] instr;
        opcode_e       opc;
        logic [DW-1:0] opnd;
        logic [DW-1:0] alu;
        logic [DW-1:0] acc;
    } exec_state_t;

    exec_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (phase)
            PH_DECODE: begin
                s_d.opc = opcode_e'(s_q.instr[IW-1 -: 2]);
            end
            PH_READ: begin
                if (s_q.opc != OP_NOP)
                    s_d.opnd = DW'(s_q.instr[OPW-1:0]);
            end
            PH_PROCESS: begin
                case (s_q.opc)
                    OP_ADD:  s_d.alu = s_q.acc + s_q.opnd;
                    OP_LOAD: s_d.alu = s_q.opnd;
                    OP_SUB:  s_d.alu = s_q.acc - s_q.opnd;
                    default: s_d.alu = s_q.alu;
                endcase
            end
            PH_WRITE: begin
                if (s_q.opc != OP_NOP)
                    s_d.acc = s_q.alu;
                s_d.instr = squash ? '0 : fetched;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign acc     = s_q.acc;
    assign wr_stb  = (phase == PH_WRITE) && (s_q.opc != OP_NOP);
    assign wr_data = s_q.alu;

    // R7: without a write strobe the accumulator holds
    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(acc));
    // R7: a write strobe commits exactly the presented data
    assert_acc_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (acc == $past(wr_data)));
endmodule

// File: rtl/qcyc_sequencer.sv
`timescale 1ns/1ps
module qcyc_sequencer
    import qcyc_pkg::*;
#(
    parameter int IW  = 8,
    parameter int DW  = 8,
    parameter int PCW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              branch_taken,
    input  logic [PCW-1:0]    branch_target,
    input  logic [IW-1:0]     imem_data,
    output logic [PCW-1:0]    imem_addr,
    output logic [PHASES-1:0] phase_oh,
    output logic              cyc_en,
    output logic              periph_en,
    output logic              wr_stb,
    output logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     acc
);
    phase_e        phase;
    logic          cyc_last;
    logic [IW-1:0] fetched;

    qcyc_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .phase_oh  (phase_oh),
        .cyc_last  (cyc_last),
        .periph_en (periph_en)
    );

    qcyc_fetch #(
        .IW  (IW),
        .PCW (PCW)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_fetch    (phase_oh[0]),
        .advance       (cyc_last),
        .branch_taken  (branch_taken),
        .branch_target (branch_target),
        .imem_data     (imem_data),
        .pc            (imem_addr),
        .fetched       (fetched)
    );

    qcyc_exec #(
        .IW (IW),
        .DW (DW)
    ) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .squash  (branch_taken),
        .fetched (fetched),
        .acc     (acc),
        .wr_stb  (wr_stb),
        .wr_data (wr_data)
    );

    assign cyc_en = cyc_last;

    // R1: exactly one phase strobe at a time
    assert_onehot_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1);
    // R3: the cycle enable lasts one clock and starts a new cycle
    assert_cycle_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en |=> (!cyc_en && phase_oh[0]));
    // R7: a write strobe only appears together with the cycle enable
    assert_write_in_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> cyc_en);
endmodule

// File: tb/qcyc_sequencer_test.sv
`timescale 1ns/1ps
module qcyc_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       branch_taken;
    logic [5:0] branch_target;
    logic [7:0] imem_data;
    logic [5:0] imem_addr;
    logic [3:0] phase_oh;
    logic       cyc_en;
    logic       periph_en;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic [7:0] acc;

    logic [7:0] rom [64];
    int checks = 0;
    int errors = 0;

    // bench model of the pipeline
    logic [5:0] exp_pc;
    logic [7:0] exp_exec;
    logic [7:0] exp_acc;

    always #4 clk = ~clk;

    assign imem_data = rom[imem_addr];

    qcyc_sequencer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .branch_taken  (branch_taken),
        .branch_target (branch_target),
        .imem_data     (imem_data),
        .imem_addr     (imem_addr),
        .phase_oh      (phase_oh),
        .cyc_en        (cyc_en),
        .periph_en     (periph_en),
        .wr_stb        (wr_stb),
        .wr_data       (wr_data),
        .acc           (acc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 64; i++) rom[i] = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        branch_taken = 1'b0;
        branch_target = '0;
        repeat (3) @(negedge clk);
        check("R1 reset phase", 32'(phase_oh), 32'h1);
        check("R4 reset periph_en", 32'(periph_en), 32'h0);
        check("R5 reset pc", 32'(imem_addr), 32'h0);
        check("R5 reset acc", 32'(acc), 32'h0);
        rst_n = 1'b1;
        exp_pc = '0;
        exp_exec = '0;
        exp_acc = '0;
    endtask

    // Runs one instruction cycle starting in the decode phase (sampled at negedge).
    task automatic run_cycle(input logic br, input logic [5:0] tgt, input logic stray);
        logic [1:0] op;
        logic [7:0] imm;
        logic       exp_wr;
        logic [7:0] exp_new;
        logic [7:0] fetched;
        op = exp_exec[7:6];
        imm = {2'b00, exp_exec[5:0]};
        exp_wr = (op != 2'b00);
        case (op)
            2'b01:   exp_new = exp_acc + imm;
            2'b10:   exp_new = imm;
            2'b11:   exp_new = exp_acc - imm;
            default: exp_new = exp_acc;
        endcase
        check("R2 decode phase", 32'(phase_oh), 32'h1);
        check("R3 no enable in decode", 32'(cyc_en), 32'h0);
        if (stray) begin
            branch_taken = 1'b1;
            branch_target = tgt;
        end
        @(posedge clk); @(negedge clk);
        check("R2 read phase", 32'(phase_oh), 32'h2);
        check("R4 periph_en", 32'(periph_en), 32'h1);
        check("R7 acc held in read", 32'(acc), 32'(exp_acc));
        check("R8 pc steady", 32'(imem_addr), 32'(exp_pc));
        @(posedge clk); @(negedge clk);
        check("R2 process phase", 32'(phase_oh), 32'h4);
        check("R3 no enable in process", 32'(cyc_en), 32'h0);
        check("R7 acc held in process", 32'(acc), 32'(exp_acc));
        branch_taken = br;
        branch_target = tgt;
        @(posedge clk); @(negedge clk);
        check("R2 write phase", 32'(phase_oh), 32'h8);
        check("R3 enable in write", 32'(cyc_en), 32'h1);
        check("R7 write strobe", 32'(wr_stb), 32'(exp_wr));
        if (exp_wr) check("R6 write data", 32'(wr_data), 32'(exp_new));
        @(posedge clk); @(negedge clk);
        branch_taken = 1'b0;
        fetched = rom[exp_pc];
        exp_exec = br ? 8'h00 : fetched;
        exp_pc = br ? tgt : exp_pc + 6'd1;
        if (exp_wr) exp_acc = exp_new;
        check("R7 acc after write", 32'(acc), 32'(exp_acc));
        check(br ? "R9 pc after branch" : (stray ? "R10 pc after stray" : "R8 pc after cycle"),
              32'(imem_addr), 32'(exp_pc));
    endtask

    task automatic test_reset();
        clear_rom();
        rom[0] = 8'h85;
        do_reset();
        // R5: first cycle executes NOP, no write strobe
        run_cycle(1'b0, 6'd0, 1'b0);
        check("R5 first cycle leaves acc", 32'(acc), 32'h0);
    endtask

    task automatic test_program();
        clear_rom();
        rom[0] = 8'h85;  // LOAD 5
        rom[1] = 8'h43;  // ADD 3
        rom[2] = 8'hCA;  // SUB 10 -> underflow
        rom[3] = 8'h00;  // NOP
        rom[4] = 8'h7F;  // ADD 63
        rom[5] = 8'h7F;  // ADD 63
        rom[6] = 8'hBF;  // LOAD 63
        do_reset();
        for (int c = 0; c < 8; c++) run_cycle(1'b0, 6'd0, 1'b0);
        check("R6 final acc", 32'(acc), 32'h3F);
    endtask

    task automatic test_branch();
        clear_rom();
        rom[0] = 8'h81;   // LOAD 1
        rom[1] = 8'h42;   // ADD 2
        rom[2] = 8'h44;   // ADD 4, squashed
        rom[3] = 8'h48;   // ADD 8, skipped
        rom[20] = 8'h50;  // ADD 16
        rom[21] = 8'hA8;  // LOAD 40
        do_reset();
        run_cycle(1'b0, 6'd0, 1'b0);
        run_cycle(1'b0, 6'd0, 1'b0);
        run_cycle(1'b1, 6'd20, 1'b0);
        run_cycle(1'b0, 6'd0, 1'b0);   // R9 bubble cycle
        check("R9 squashed instruction had no effect", 32'(acc), 32'h3);
        run_cycle(1'b0, 6'd0, 1'b0);
        run_cycle(1'b0, 6'd0, 1'b0);
        check("R9 target path executed", 32'(acc), 32'h28);
    endtask

    task automatic test_stray();
        clear_rom();
        rom[0] = 8'h81;
        rom[1] = 8'h42;
        rom[2] = 8'h44;
        rom[3] = 8'h48;
        do_reset();
        for (int c = 0; c < 5; c++) run_cycle(1'b0, 6'd30, 1'b1);
        check("R10 stray branch ignored", 32'(acc), 32'h0F);
    endtask

    task automatic test_wrap();
        clear_rom();
        rom[62] = 8'h41;
        rom[63] = 8'h42;
        rom[0]  = 8'h44;
        do_reset();
        run_cycle(1'b1, 6'd62, 1'b0);
        for (int c = 0; c < 4; c++) run_cycle(1'b0, 6'd0, 1'b0);
        check("R8 wrap past 63", 32'(acc), 32'h07);
    endtask

    initial begin
        test_reset();
        test_program();
        test_branch();
        test_stray();
        test_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule